// File: doc/BRIEF.md
# I2C Bus START/STOP Condition Detector

This block watches the SCL and SDA lines of an I2C bus and reports START and STOP conditions. It accepts one only when strict timing rules are met. Both lines first pass through two-flop synchronizers, and every timing count is taken on the synchronized copies.

An SDA edge while SCL is high becomes a candidate condition. The candidate is accepted only when three checks pass. SCL must have been high long enough before the edge (release). SDA must have held its old level long enough before the edge (setup). SCL must stay high and SDA must stay at its new level long enough after the edge (hold). The hold check rejects short SDA glitches.

An accepted condition produces a one-cycle pulse and updates a bus-busy flag after a delay that depends on the mode. A STOP seen while the device acts as a slave raises an interrupt, which stays up until it is acknowledged. All limits come from a five-bit timing setting in standard mode, or from fixed small values in high-speed mode.

Top module: `i2c_cond_detect`

## Requirements
- R1: A START (SDA falls while SCL is high, qualified) gives a one-cycle `start_det` pulse and sets `bus_busy` to 1. A START while already busy still pulses and leaves `bus_busy` at 1.
- R2: A STOP (SDA rises while SCL is high, qualified) gives a one-cycle `stop_det` pulse and clears `bus_busy` to 0.
- R3: Release rule. The synchronized SCL must have been high for at least REL consecutive cycles before the synchronized SDA edge. REL is `cond_time`+1 in standard mode (`fast_mode`=0) and 4 in high-speed mode (`fast_mode`=1). A shorter high time gives no pulse and leaves `bus_busy` unchanged.
- R4: Setup rule. SDA must have held its previous level for at least WIN cycles before its edge. WIN is ceil((`cond_time`+1)/2) in standard mode and 2 in high-speed mode. A shorter setup gives no pulse and leaves `bus_busy` unchanged.
- R5: Hold rule. Counting the edge cycle, SCL must stay high and SDA must stay at its new level for WIN cycles. If either changes sooner, the candidate is dropped, with no pulse and `bus_busy` unchanged.
- R6: The pulse and the `bus_busy` update appear DLY cycles after the synchronized SDA edge. DLY is `cond_time`/2+2 in standard mode and 4 in high-speed mode (3.5 rounded up). Measured from a raw SDA change made just after a clock edge, the result is visible after the (DLY+2)-th following rising edge.
- R7: In the cycle `stop_det` pulses, `stop_irq` rises if `master_mode` was 0 in the previous cycle. It then stays at 1 until `irq_ack` is high at a clock edge. A STOP in master mode leaves `stop_irq` low.
- R8: A `cond_time` of 0 or any odd value is illegal. `cfg_err` goes to 1 one cycle later. While the setting is illegal, no condition is detected and `bus_busy` holds.
- R9: While `rst_n` is low, `bus_busy`, both pulses, `stop_irq` and `cfg_err` are 0 and all counters are cleared.
- R10: SDA changes while SCL is low cause no pulse and no change of `bus_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_time | input | 5 | Condition timing setting, even and nonzero |
| fast_mode | input | 1 | 1 selects high-speed fixed timing |
| master_mode | input | 1 | 1 when the device is bus master |
| scl_in | input | 1 | Raw SCL level |
| sda_in | input | 1 | Raw SDA level |
| irq_ack | input | 1 | Clears the pending interrupt |
| bus_busy | output | 1 | Bus busy flag |
| start_det | output | 1 | One-cycle START pulse |
| stop_det | output | 1 | One-cycle STOP pulse |
| stop_irq | output | 1 | STOP-in-slave-mode interrupt request |
| cfg_err | output | 1 | Illegal timing setting |

## Verification
The bench places SDA edges exactly at, and one cycle short of, the release, setup and hold limits in both modes.

- A design that counts release or setup off by one would accept the short case or reject the exact one.
- A design without the hold check would report a START for a one-cycle SDA glitch.
- A scoreboard stamps each expected pulse with its cycle, so a wrong DLY or a missing synchronizer stage shows up as a cycle mismatch.
- Further checks cover an illegal setting that still lets conditions through, and an interrupt that rises in master mode or clears before it is acknowledged.

// File: rtl/i2c_cond_pkg.sv
// Shared constants for the START/STOP condition detector.
// Assumes a condition setting narrow enough that CFG_W+1 bit counters hold every limit.
package i2c_cond_pkg;

    // fixed high-speed limits, in system clock cycles
    localparam int HS_REL_CYC = 4;
    localparam int HS_WIN_CYC = 2;
    localparam int HS_DLY_CYC = 4;

    // depth of the input synchronizer chain
    localparam int SYNC_DEPTH = 2;

    // kind of a pending candidate condition
    typedef enum logic {
        COND_START = 1'b0,
        COND_STOP  = 1'b1
    } cond_kind_e;

endpackage

// File: rtl/i2c_cond_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous line inputs.
// Assumes each bit is independent; the reset value is the idle level of the lines.
module i2c_cond_sync #(
    parameter int                 W       = 2,
    parameter int                 STAGES  = 2,
    parameter logic [W-1:0]       RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first flop samples the raw line
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= d_in;
                end
            end else begin : g_next
                // later flops resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RST_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stg[STAGES-1];

endmodule

// File: rtl/i2c_cond_timing.sv
// Turns the condition setting and mode into release, window and delay limits.
// Flags illegal settings (zero or odd); half cycles are rounded up.
module i2c_cond_timing #(
    parameter int CFG_W  = 5,
    parameter int CNT_W  = CFG_W + 1,
    parameter int HS_REL = 4,
    parameter int HS_WIN = 2,
    parameter int HS_DLY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             hs,
    output logic [CNT_W-1:0] rel_lim,
    output logic [CNT_W-1:0] win_lim,
    output logic [CNT_W-1:0] dly_lim,
    output logic             cfg_bad,
    output logic             cfg_err
);

    logic [CNT_W-1:0] cfg_x;

    assign cfg_x = CNT_W'(cfg);

    // illegal setting: zero or odd
    always_comb cfg_bad = (cfg == '0) || cfg[0];

    // limit selection for the two modes
    always_comb begin
        if (hs) begin
            rel_lim = CNT_W'(HS_REL);
            win_lim = CNT_W'(HS_WIN);
            dly_lim = CNT_W'(HS_DLY);
        end else begin
            rel_lim = cfg_x + CNT_W'(1);
            win_lim = (cfg_x + CNT_W'(2)) >> 1;
            dly_lim = ((cfg_x + CNT_W'(1)) >> 1) + CNT_W'(2);
        end
    end

    // registered error flag for the outside
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= cfg_bad;
    end

endmodule

// File: rtl/i2c_cond_qual.sv
// Qualifies SDA edges seen while SCL is high against release, setup and hold limits.
// Once a condition is accepted it updates the busy flag after the delay limit.
// Assumes synchronized inputs and limits with dly_lim > win_lim >= 1.
module i2c_cond_qual
    import i2c_cond_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic [CNT_W-1:0] rel_lim,
    input  logic [CNT_W-1:0] win_lim,
    input  logic [CNT_W-1:0] dly_lim,
    output logic             stop_fire,
    output logic             busy,
    output logic             start_p,
    output logic             stop_p
);

    logic             sda_q;
    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] st_q;
    logic [CNT_W-1:0] age_q;
    logic             pend_q;
    cond_kind_e       kind_q;
    logic             sda_edge;
    logic             cand_ok;
    logic             hold_bad;
    logic             fire;

    assign sda_edge = (sda_s != sda_q);

    // a new candidate needs SCL high and all release and setup limits met
    always_comb cand_ok = en && scl_s && sda_edge && !pend_q
                          && (hi_q >= rel_lim) && (st_q >= win_lim);

    // the hold window is broken by SCL falling or SDA returning
    always_comb hold_bad = pend_q && (age_q < win_lim)
                           && (!scl_s || (sda_s != kind_q));

    // an accepted candidate matures after the delay limit
    always_comb fire = pend_q && en && !hold_bad && (age_q == dly_lim - CNT_W'(1));

    assign stop_fire = fire && (kind_q == COND_STOP);

    // previous synchronized SDA level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sda_q <= 1'b1;
        else        sda_q <= sda_s;
    end

    // saturating count of consecutive SCL high cycles
    always_ff @(posedge clk) begin
        if (!rst_n)          hi_q <= '0;
        else if (!scl_s)     hi_q <= '0;
        else if (hi_q != '1) hi_q <= hi_q + CNT_W'(1);
    end

    // saturating count of cycles since the last SDA change
    always_ff @(posedge clk) begin
        if (!rst_n)          st_q <= '0;
        else if (sda_edge)   st_q <= CNT_W'(1);
        else if (st_q != '1) st_q <= st_q + CNT_W'(1);
    end

    // candidate tracking: start, age, abort and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            kind_q <= COND_START;
            age_q  <= '0;
        end else if (!en || hold_bad || fire) begin
            pend_q <= 1'b0;
            age_q  <= '0;
        end else if (cand_ok) begin
            pend_q <= 1'b1;
            kind_q <= sda_s ? COND_STOP : COND_START;
            age_q  <= CNT_W'(1);
        end else if (pend_q) begin
            age_q  <= age_q + CNT_W'(1);
        end
    end

    // busy flag and one-cycle event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            start_p <= 1'b0;
            stop_p  <= 1'b0;
        end else begin
            start_p <= fire && (kind_q == COND_START);
            stop_p  <= fire && (kind_q == COND_STOP);
            if (fire) busy <= (kind_q == COND_START);
        end
    end

endmodule

// File: rtl/i2c_cond_irq.sv
// Latches a request when a STOP completes in slave mode; held until acknowledged.
// Assumes a new STOP wins over an acknowledge in the same cycle.
module i2c_cond_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_fire,
    input  logic master,
    input  logic ack,
    output logic irq
);

    // set on slave STOP, clear on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)                   irq <= 1'b0;
        else if (stop_fire && !master) irq <= 1'b1;
        else if (ack)                 irq <= 1'b0;
    end

endmodule

// File: rtl/i2c_cond_detect.sv
// Top of the START/STOP condition detector: synchronizers, limit decode,
// edge qualification and the slave STOP interrupt.
// Assumes raw SCL/SDA idle high and a single clock domain for everything else.
module i2c_cond_detect
    import i2c_cond_pkg::*;
#(
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cond_time,
    input  logic             fast_mode,
    input  logic             master_mode,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             irq_ack,
    output logic             bus_busy,
    output logic             start_det,
    output logic             stop_det,
    output logic             stop_irq,
    output logic             cfg_err
);

    localparam int CNT_W = CFG_W + 1;

    logic [1:0]       lines_s;
    logic [CNT_W-1:0] rel_lim;
    logic [CNT_W-1:0] win_lim;
    logic [CNT_W-1:0] dly_lim;
    logic             cfg_bad;
    logic             stop_fire;

    i2c_cond_sync #(
        .W       (2),
        .STAGES  (SYNC_DEPTH),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out (lines_s)
    );

    i2c_cond_timing #(
        .CFG_W  (CFG_W),
        .CNT_W  (CNT_W),
        .HS_REL (HS_REL_CYC),
        .HS_WIN (HS_WIN_CYC),
        .HS_DLY (HS_DLY_CYC)
    ) u_timing (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cond_time),
        .hs      (fast_mode),
        .rel_lim (rel_lim),
        .win_lim (win_lim),
        .dly_lim (dly_lim),
        .cfg_bad (cfg_bad),
        .cfg_err (cfg_err)
    );

    i2c_cond_qual #(
        .CNT_W (CNT_W)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (!cfg_bad),
        .scl_s     (lines_s[1]),
        .sda_s     (lines_s[0]),
        .rel_lim   (rel_lim),
        .win_lim   (win_lim),
        .dly_lim   (dly_lim),
        .stop_fire (stop_fire),
        .busy      (bus_busy),
        .start_p   (start_det),
        .stop_p    (stop_det)
    );

    i2c_cond_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_fire (stop_fire),
        .master    (master_mode),
        .ack       (irq_ack),
        .irq       (stop_irq)
    );

endmodule

// File: rtl/i2c_cond_detect_chk.sv
// Property checker for the condition detector, attached to the top by bind.
module i2c_cond_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic master_mode,
    input logic irq_ack,
    input logic bus_busy,
    input logic start_det,
    input logic stop_det,
    input logic stop_irq,
    input logic cfg_err
);

    // R1
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> start_det);

    // R2
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |-> stop_det);

    // R1
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det}));

    // R1
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !start_det);

    // R2
    stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !stop_det);

    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !$past(master_mode)) |-> stop_irq);

    // R7
    irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_irq && !irq_ack) |=> stop_irq);

    // R8
    cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!start_det && !stop_det && $stable(bus_busy)));

endmodule

bind i2c_cond_detect i2c_cond_detect_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .irq_ack     (irq_ack),
    .bus_busy    (bus_busy),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .stop_irq    (stop_irq),
    .cfg_err     (cfg_err)
);

// File: tb/test_i2c_cond_detect.sv
module test_i2c_cond_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cond_time = 5'd6;
    logic       fast_mode = 1'b0;
    logic       master_mode = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       irq_ack = 1'b0;
    logic       bus_busy, start_det, stop_det, stop_irq, cfg_err;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    typedef struct {
        bit    stp;
        int    at;
        string tag;
    } ev_t;

    ev_t exq[$];

    i2c_cond_detect i_i2c_cond_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .cond_time   (cond_time),
        .fast_mode   (fast_mode),
        .master_mode (master_mode),
        .scl_in      (scl_in),
        .sda_in      (sda_in),
        .irq_ack     (irq_ack),
        .bus_busy    (bus_busy),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .stop_irq    (stop_irq),
        .cfg_err     (cfg_err)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_dly();
        return fast_mode ? 4 : (int'(cond_time) / 2 + 2);
    endfunction

    // driver side of the scoreboard: expected pulse and its cycle
    task automatic expect_evt(input bit stp, input string tag);
        ev_t e;
        e.stp = stp;
        e.at  = cyc + exp_dly() + 2;
        e.tag = tag;
        exq.push_back(e);
    endtask

    // monitor side: pops and compares each produced pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (exq.size() > 0 && exq[0].at < cyc) begin
                total++; bad++;
                $display("FAIL %s missing pulse actual=none expected=cycle %0d", exq[0].tag, exq[0].at);
                void'(exq.pop_front());
            end
            if (start_det || stop_det) begin
                if (exq.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R3/R4/R5/R8/R10 unexpected pulse actual=stop:%0d at %0d expected=none",
                             stop_det, cyc);
                end else begin
                    ev_t e;
                    e = exq.pop_front();
                    chk(e.at == cyc && e.stp == stop_det, e.tag, cyc, e.at);
                end
            end
        end
    end

    // SCL low, set SDA, SCL high again, without forming a condition
    task automatic reline(input logic sda_v);
        scl_in = 1'b0; tick(2);
        sda_in = sda_v; tick(2);
        scl_in = 1'b1;
    endtask

    task automatic ack_irq();
        irq_ack = 1'b1; tick(1);
        irq_ack = 1'b0; tick(1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(5);
        // R9 reset state
        chk(!bus_busy && !start_det && !stop_det && !stop_irq && !cfg_err, "R9 reset outputs",
            {bus_busy, start_det, stop_det, stop_irq, cfg_err}, 0);
        rst_n = 1'b1;
        tick(30);

        // R1 R6 standard START
        sda_in = 1'b0; expect_evt(1'b0, "R1 R6 start std");
        tick(12);
        chk(bus_busy, "R1 busy after start", bus_busy, 1);

        // R10 SDA toggles with SCL low
        scl_in = 1'b0; tick(2);
        sda_in = 1'b1; tick(2); sda_in = 1'b0; tick(2);
        scl_in = 1'b1; tick(3); scl_in = 1'b0; tick(1);
        sda_in = 1'b1; tick(2); scl_in = 1'b1; tick(12);
        chk(bus_busy, "R10 busy kept", bus_busy, 1);

        // R1 repeated START
        tick(10);
        sda_in = 1'b0; expect_evt(1'b0, "R1 repeated start");
        tick(12);
        chk(bus_busy, "R1 busy stays", bus_busy, 1);

        // R2 R7 slave STOP
        reline(1'b0); tick(10);
        sda_in = 1'b1; expect_evt(1'b1, "R2 R6 stop std");
        tick(12);
        chk(!bus_busy, "R2 busy cleared", bus_busy, 0);
        chk(stop_irq, "R7 irq raised", stop_irq, 1);
        tick(5);
        chk(stop_irq, "R7 irq held", stop_irq, 1);
        ack_irq();
        chk(!stop_irq, "R7 irq acked", stop_irq, 0);

        // R3 release one short, then exact
        reline(1'b1); tick(6);
        sda_in = 1'b0; tick(12);
        chk(!bus_busy, "R3 short release rejected", bus_busy, 0);
        reline(1'b1); tick(7);
        sda_in = 1'b0; expect_evt(1'b0, "R3 exact release");
        tick(12);
        chk(bus_busy, "R3 busy after exact release", bus_busy, 1);

        // R5 hold one short, then exact
        reline(1'b0); tick(10);
        sda_in = 1'b1; tick(3); scl_in = 1'b0; tick(12);
        chk(bus_busy, "R5 short hold rejected", bus_busy, 1);
        sda_in = 1'b0; tick(2); scl_in = 1'b1; tick(10);
        sda_in = 1'b1; expect_evt(1'b1, "R5 exact hold");
        tick(4); scl_in = 1'b0; tick(12);
        chk(!bus_busy, "R5 busy after exact hold", bus_busy, 0);
        ack_irq();
        scl_in = 1'b1; tick(20);

        // R5 glitch, then R4 setup one short
        sda_in = 1'b0; tick(1); sda_in = 1'b1; tick(3);
        sda_in = 1'b0; tick(12);
        chk(!bus_busy, "R4 R5 glitch and short setup rejected", bus_busy, 0);
        reline(1'b1); tick(20);
        sda_in = 1'b0; tick(1); sda_in = 1'b1; tick(4);
        sda_in = 1'b0; expect_evt(1'b0, "R4 exact setup");
        tick(12);
        chk(bus_busy, "R4 busy after exact setup", bus_busy, 1);

        // R7 master STOP, no interrupt
        master_mode = 1'b1;
        reline(1'b0); tick(10);
        sda_in = 1'b1; expect_evt(1'b1, "R2 master stop");
        tick(12);
        chk(!bus_busy && !stop_irq, "R7 no irq in master", stop_irq, 0);
        master_mode = 1'b0;

        // R3 R6 high-speed mode
        fast_mode = 1'b1;
        reline(1'b1); tick(3);
        sda_in = 1'b0; tick(10);
        chk(!bus_busy, "R3 hs short release rejected", bus_busy, 0);
        reline(1'b1); tick(4);
        sda_in = 1'b0; expect_evt(1'b0, "R6 hs start");
        tick(10);
        chk(bus_busy, "R6 hs busy", bus_busy, 1);
        reline(1'b0); tick(4);
        sda_in = 1'b1; expect_evt(1'b1, "R6 hs stop");
        tick(10);
        chk(!bus_busy && stop_irq, "R6 R7 hs stop", {bus_busy, stop_irq}, 1);
        ack_irq();
        fast_mode = 1'b0;

        // R8 illegal settings
        cond_time = 5'd5; tick(2);
        chk(cfg_err, "R8 odd flagged", cfg_err, 1);
        tick(20);
        sda_in = 1'b0; tick(15);
        chk(!bus_busy, "R8 odd blocks start", bus_busy, 0);
        cond_time = 5'd0; tick(2);
        chk(cfg_err, "R8 zero flagged", cfg_err, 1);
        reline(1'b1);
        cond_time = 5'd6; tick(2);
        chk(!cfg_err, "R8 legal clears", cfg_err, 0);
        tick(20);
        sda_in = 1'b0; expect_evt(1'b0, "R8 start after legal");
        tick(12);
        chk(bus_busy, "R8 busy after legal", bus_busy, 1);

        tick(20);
        chk(exq.size() == 0, "R1 R2 scoreboard drained", exq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule